// File: doc/BRIEF.md
# Register-Mapped Transmit Byte Queue

This block is a circular byte buffer that sits between a processor and a transmitter in a low-rate wireless MAC. The processor fills it one byte at a time through a small byte-wide register bank. The same bank lets the processor read and overwrite both queue pointers, read the status flags and the fill level, enable the queue, and clear it. A transmitter on the far side pulls bytes out through a ready/valid pop port. Each popped byte appears one cycle after the handshake.

Two further registers mark a region of the queued data for an encryption engine: a start address and a length. Both go out on plain pins. The processor can write them directly. It can also set an automatic mode. In that mode the first byte pushed into an empty queue is taken as the packet length, and the region is loaded from it.

The processor side has no back-pressure. A push that the queue cannot accept is dropped, and the processor is expected to check the full flag first. The transmitter side works by back-pressure. `tx_avail` is high when the queue is enabled and holds data. A byte is transferred in every cycle where `tx_avail` and `tx_ready` are both high. The transmitter stalls the queue by holding `tx_ready` low.

Top module: `tx_byte_queue`

## Requirements
- R1: A register write to offset 0 with the queue enabled and not full stores the write data at the address given by the write pointer's low 8 bits. It then advances the 9-bit write pointer by one.
- R2: `tx_avail` equals enable AND NOT empty. A transfer (`tx_avail` and `tx_ready` both high at a clock edge) advances the read pointer by one. At the following edge, `tx_data` holds the byte at the old read address and `tx_data_vld` is high for exactly one cycle. Bytes leave in the order they were pushed.
- R3: A push while full, a pop while empty, and any push or pop while enable is 0 are ignored: the pointers do not change.
- R4: Status (offset 4, read-only): bit 7 is the write-pointer MSB and bit 6 is the read-pointer MSB. Bit 1 is full: the low bits are equal and the MSBs differ. Bit 0 is empty: all 9 bits are equal. The other bits read 0.
- R5: Fill count (offset 5) reads the low 8 bits of write pointer minus read pointer. A full queue therefore reads 0 with the full flag set.
- R6: Offsets 1 and 2 read and write the low 8 bits of the write and read pointers; a write keeps the pointer's MSB. Flags and count reflect the new value from the next cycle on. A write to the read pointer wins over a transfer in the same cycle; the popped byte is still delivered.
- R7: Control (offset 3): bit 2 is automatic region setup, bit 1 is enable, and bit 0 is clear. Clear is self-clearing and reads 0; bits 7:3 read 0. Writing 1 to clear zeroes both 9-bit pointers, which gives status 0x01 and count 0. A transfer in the same cycle is cancelled.
- R8: Offset 7 (region start) and offset 8 (region length) are read/write. Their values drive `enc_start` and `enc_len`.
- R9: With automatic setup on, an accepted push into an empty queue loads the region start with that byte's address plus one (mod 256) and the region length with the byte's value. Pushes into a non-empty queue leave both unchanged.
- R10: After reset every register reads 0x00 except status, which reads 0x01. Offset 0 and unmapped offsets read 0x00.
- R11: A push and a transfer in the same cycle both take effect, and the fill count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| tx_ready | input | 1 | Transmitter accepts a byte this cycle |
| tx_avail | output | 1 | Queue enabled and non-empty |
| tx_data | output | 8 | Popped byte, one cycle after transfer |
| tx_data_vld | output | 1 | `tx_data` is valid this cycle |
| enc_start | output | 8 | Encryption region start address |
| enc_len | output | 8 | Encryption region length |

## Verification
The hardest state to reach from the ports is a full queue whose write pointer has wrapped into the other 9-bit half. At that point the MSBs differ and the count register reads 0. The stimulus gets there by moving the pointers to a non-zero base, pushing exactly 256 bytes, trying one push too many, and then pushing and popping in the same cycle. A second hard corner is automatic region capture at address 0xFF, where the start address wraps to 0x00. The bench reaches it by clearing the queue and writing both pointers to 0xFF before pushing a length byte.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] OFS_PUSH   = 4'd0;
  localparam logic [REG_AW-1:0] OFS_WPTR   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_RPTR   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_CTRL   = 4'd3;
  localparam logic [REG_AW-1:0] OFS_STAT   = 4'd4;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_ESTART = 4'd7;
  localparam logic [REG_AW-1:0] OFS_ELEN   = 4'd8;

  typedef struct packed {
    logic push;
    logic wp_we;
    logic rp_we;
    logic clr;
    logic es_we;
    logic el_we;
  } wr_strobe_t;
endpackage

// File: rtl/txq_csr.sv
module txq_csr
  import txq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [2:0]        ctrl_bits,
  input  logic [PTR_W:0]    wptr,
  input  logic [PTR_W:0]    rptr,
  input  logic              full,
  input  logic              empty,
  input  logic [7:0]        count,
  input  logic [7:0]        enc_start,
  input  logic [7:0]        enc_len,
  output wr_strobe_t        stb,
  output logic              fifo_en,
  output logic              auto_rgn,
  output logic [7:0]        reg_rdata
);
  always_comb begin
    stb       = '0;
    stb.push  = reg_wr && (reg_addr == OFS_PUSH);
    stb.wp_we = reg_wr && (reg_addr == OFS_WPTR);
    stb.rp_we = reg_wr && (reg_addr == OFS_RPTR);
    stb.clr   = reg_wr && (reg_addr == OFS_CTRL) && ctrl_bits[0];
    stb.es_we = reg_wr && (reg_addr == OFS_ESTART);
    stb.el_we = reg_wr && (reg_addr == OFS_ELEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      auto_rgn <= 1'b0;
    end else if (reg_wr && (reg_addr == OFS_CTRL)) begin
      fifo_en  <= ctrl_bits[1];
      auto_rgn <= ctrl_bits[2];
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      OFS_WPTR:   reg_rdata = 8'(wptr[PTR_W-1:0]);
      OFS_RPTR:   reg_rdata = 8'(rptr[PTR_W-1:0]);
      OFS_CTRL:   reg_rdata = {5'b0, auto_rgn, fifo_en, 1'b0};
      OFS_STAT:   reg_rdata = {wptr[PTR_W], rptr[PTR_W], 4'b0, full, empty};
      OFS_COUNT:  reg_rdata = count;
      OFS_ESTART: reg_rdata = enc_start;
      OFS_ELEN:   reg_rdata = enc_len;
      default:    reg_rdata = 8'h00;
    endcase
  end

  // R7: a control write sets the enable field from data bit 1
  p_ctrl_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL) |=> (fifo_en == $past(ctrl_bits[1])));
endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
  import txq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       stb,
  input  logic [7:0]       wdata,
  input  logic             fifo_en,
  input  logic             tx_ready,
  output logic             tx_avail,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W:0]   wptr,
  output logic [PTR_W:0]   rptr,
  output logic             full,
  output logic             empty,
  output logic [7:0]       count
);
  logic [PTR_W:0] fill;

  assign empty    = (wptr == rptr);
  assign full     = (wptr[PTR_W-1:0] == rptr[PTR_W-1:0]) && (wptr[PTR_W] != rptr[PTR_W]);
  assign fill     = wptr - rptr;
  assign count    = 8'(fill);
  assign tx_avail = fifo_en && !empty;
  assign push_ok  = stb.push && fifo_en && !full;
  assign pop_ok   = tx_ready && tx_avail && !stb.clr;

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clr) begin
      wptr <= '0;
    end else if (stb.wp_we) begin
      wptr <= {wptr[PTR_W], wdata[PTR_W-1:0]};
    end else if (push_ok) begin
      wptr <= wptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clr) begin
      rptr <= '0;
    end else if (stb.rp_we) begin
      rptr <= {rptr[PTR_W], wdata[PTR_W-1:0]};
    end else if (pop_ok) begin
      rptr <= rptr + 1'b1;
    end
  end

  p_push_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.push && fifo_en && !full && !stb.clr && !stb.wp_we) |=> (wptr == $past(wptr) + 1'b1));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.push && full && !stb.clr && !stb.wp_we) |=> $stable(wptr));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && empty && !stb.clr && !stb.rp_we) |=> $stable(rptr));
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clr |=> (wptr == '0 && rptr == '0));
  p_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok && !stb.wp_we && !stb.rp_we) |=> (count == $past(count)));
endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_ok,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             pop_ok,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       tx_data,
  output logic             tx_data_vld
);
  localparam int DEPTH = 1 << PTR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (push_ok) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data     <= 8'h00;
      tx_data_vld <= 1'b0;
    end else begin
      tx_data_vld <= pop_ok;
      if (pop_ok) tx_data <= mem[raddr];
    end
  end

  // R2: a transfer produces exactly one valid beat on the next cycle
  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> tx_data_vld);
  p_vld_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_ok |=> !tx_data_vld);
endmodule

// File: rtl/txq_region.sv
module txq_region
  import txq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_strobe_t       stb,
  input  logic [7:0]       wdata,
  input  logic             auto_rgn,
  input  logic             push_ok,
  input  logic             empty,
  input  logic [PTR_W-1:0] waddr,
  output logic [7:0]       enc_start,
  output logic [7:0]       enc_len
);
  logic [PTR_W-1:0] next_addr;
  logic             capture;

  assign next_addr = waddr + 1'b1;
  assign capture   = auto_rgn && push_ok && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_start <= 8'h00;
      enc_len   <= 8'h00;
    end else begin
      if (stb.es_we)      enc_start <= wdata;
      else if (capture)   enc_start <= 8'(next_addr);
      if (stb.el_we)      enc_len   <= wdata;
      else if (capture)   enc_len   <= wdata;
    end
  end

  p_auto_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rgn && push_ok && empty) |=> (enc_len == $past(wdata)));
  p_auto_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !empty) |=> ($stable(enc_start) && $stable(enc_len)));
  p_direct_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.es_we |=> (enc_start == $past(wdata)));
endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue
  import txq_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              tx_ready,
  output logic              tx_avail,
  output logic [7:0]        tx_data,
  output logic              tx_data_vld,
  output logic [7:0]        enc_start,
  output logic [7:0]        enc_len
);
  wr_strobe_t     stb;
  logic           fifo_en, auto_rgn;
  logic           push_ok, pop_ok, full, empty;
  logic [PTR_W:0] wptr, rptr;
  logic [7:0]     count;

  txq_csr #(.PTR_W(PTR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .ctrl_bits(reg_wdata[2:0]), .wptr(wptr), .rptr(rptr), .full(full),
    .empty(empty), .count(count), .enc_start(enc_start), .enc_len(enc_len),
    .stb(stb), .fifo_en(fifo_en), .auto_rgn(auto_rgn), .reg_rdata(reg_rdata)
  );

  txq_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(reg_wdata), .fifo_en(fifo_en),
    .tx_ready(tx_ready), .tx_avail(tx_avail), .push_ok(push_ok), .pop_ok(pop_ok),
    .wptr(wptr), .rptr(rptr), .full(full), .empty(empty), .count(count)
  );

  txq_store #(.PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .waddr(wptr[PTR_W-1:0]),
    .wdata(reg_wdata), .pop_ok(pop_ok), .raddr(rptr[PTR_W-1:0]),
    .tx_data(tx_data), .tx_data_vld(tx_data_vld)
  );

  txq_region #(.PTR_W(PTR_W)) u_region (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(reg_wdata), .auto_rgn(auto_rgn),
    .push_ok(push_ok), .empty(empty), .waddr(wptr[PTR_W-1:0]),
    .enc_start(enc_start), .enc_len(enc_len)
  );

  // R2: the pop port only offers data when enabled and holding bytes
  p_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_avail |-> (fifo_en && !empty));
endmodule

// File: tb/test_tx_byte_queue.sv
module test_tx_byte_queue;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reg_addr;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tx_ready;
  logic       tx_avail;
  logic [7:0] tx_data;
  logic       tx_data_vld;
  logic [7:0] enc_start;
  logic [7:0] enc_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] expq [$];

  always #5 clk = ~clk;

  tx_byte_queue i_tx_byte_queue (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ready(tx_ready),
    .tx_avail(tx_avail), .tx_data(tx_data), .tx_data_vld(tx_data_vld),
    .enc_start(enc_start), .enc_len(enc_len)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input bit accepted);
    if (accepted) expq.push_back(d);
    wr(4'd0, d);
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic pop_cycles(input int n);
    tx_ready = 1'b1;
    repeat (n) @(negedge clk);
    tx_ready = 1'b0;
  endtask

  // scoreboard monitor: R2 ordering and one-cycle data
  always @(negedge clk) begin
    if (rst_n && tx_data_vld) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected byte", tx_data, 0);
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        check(tx_data == e, "R2 pop data", tx_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 4'd0; reg_wr = 1'b0; reg_wdata = 8'h00; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset values
    rd_chk(4'd4, 8'h01, "R10 status reset");
    rd_chk(4'd3, 8'h00, "R10 ctrl reset");
    rd_chk(4'd1, 8'h00, "R10 wptr reset");
    rd_chk(4'd2, 8'h00, "R10 rptr reset");
    rd_chk(4'd5, 8'h00, "R10 count reset");
    rd_chk(4'd7, 8'h00, "R10 start reset");
    rd_chk(4'd8, 8'h00, "R10 len reset");
    rd_chk(4'd6, 8'h00, "R10 unmapped");
    rd_chk(4'd0, 8'h00, "R10 push offset");
    check(tx_avail == 1'b0, "R2 avail at reset", tx_avail, 0);

    // R3 push while disabled
    push(8'h5A, 1'b0);
    rd_chk(4'd1, 8'h00, "R3 disabled push wptr");
    rd_chk(4'd4, 8'h01, "R3 disabled push status");

    // R7 enable
    wr(4'd3, 8'hFA);
    rd_chk(4'd3, 8'h02, "R7 ctrl readback");

    // R1 R4 R5 basic pushes
    for (int i = 0; i < 5; i++) push(8'h10 + 8'(i), 1'b1);
    rd_chk(4'd1, 8'h05, "R1 wptr after 5");
    rd_chk(4'd5, 8'h05, "R5 count 5");
    rd_chk(4'd4, 8'h00, "R4 status partial");
    check(tx_avail == 1'b1, "R2 avail with data", tx_avail, 1);

    // R2 drain, R3 pop while empty
    pop_cycles(10);
    @(negedge clk);
    rd_chk(4'd2, 8'h05, "R3 rptr after drain and empty pops");
    rd_chk(4'd4, 8'h01, "R4 status empty");
    check(expq.size() == 0, "R2 drained", expq.size(), 0);

    // R4 R5 full with wrapped MSB
    for (int i = 0; i < 256; i++) push(8'(i * 7 + 3), 1'b1);
    rd_chk(4'd4, 8'h82, "R4 status full wrapped");
    rd_chk(4'd5, 8'h00, "R5 count when full");
    push(8'hEE, 1'b0);
    rd_chk(4'd1, 8'h05, "R3 push while full wptr");
    rd_chk(4'd4, 8'h82, "R3 push while full status");

    // R11 push and pop together
    pop_cycles(1);
    rd_chk(4'd5, 8'hFF, "R5 count 255");
    expq.push_back(8'hC3);
    reg_addr = 4'd0; reg_wdata = 8'hC3; reg_wr = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tx_ready = 1'b0;
    rd_chk(4'd5, 8'hFF, "R11 count after push+pop");
    rd_chk(4'd1, 8'h06, "R11 wptr advanced");
    rd_chk(4'd2, 8'h07, "R11 rptr advanced");
    pop_cycles(300);
    @(negedge clk);
    check(expq.size() == 0, "R2 full drain", expq.size(), 0);
    rd_chk(4'd4, 8'hC1, "R4 empty both MSB set");

    // R6 pointer writes
    wr(4'd1, 8'h10);
    rd_chk(4'd1, 8'h10, "R6 wptr write");
    rd_chk(4'd5, 8'h0A, "R6 count after wptr write");
    rd_chk(4'd4, 8'hC0, "R6 status after wptr write");
    wr(4'd2, 8'h10);
    rd_chk(4'd4, 8'hC1, "R6 status after rptr write");

    // R7 clear
    wr(4'd3, 8'h03);
    rd_chk(4'd1, 8'h00, "R7 clear wptr");
    rd_chk(4'd2, 8'h00, "R7 clear rptr");
    rd_chk(4'd4, 8'h01, "R7 clear status");
    rd_chk(4'd5, 8'h00, "R7 clear count");
    rd_chk(4'd3, 8'h02, "R7 clear self-clears");

    // R8 region registers
    wr(4'd7, 8'h33);
    wr(4'd8, 8'h44);
    rd_chk(4'd7, 8'h33, "R8 start readback");
    rd_chk(4'd8, 8'h44, "R8 len readback");
    check(enc_start == 8'h33 && enc_len == 8'h44, "R8 region pins", {enc_start, enc_len}, 16'h3344);

    // R9 automatic capture
    wr(4'd3, 8'h06);
    push(8'h07, 1'b1);
    check(enc_start == 8'h01, "R9 auto start", enc_start, 8'h01);
    check(enc_len == 8'h07, "R9 auto len", enc_len, 8'h07);
    for (int i = 0; i < 7; i++) push(8'hA0 + 8'(i), 1'b1);
    check(enc_start == 8'h01 && enc_len == 8'h07, "R9 hold while non-empty", {enc_start, enc_len}, 16'h0107);
    pop_cycles(20);
    push(8'h03, 1'b1);
    check(enc_start == 8'h09 && enc_len == 8'h03, "R9 second packet", {enc_start, enc_len}, 16'h0903);
    pop_cycles(4);
    wr(4'd3, 8'h07);
    wr(4'd1, 8'hFF);
    wr(4'd2, 8'hFF);
    push(8'h02, 1'b1);
    check(enc_start == 8'h00 && enc_len == 8'h02, "R9 start wraps", {enc_start, enc_len}, 16'h0002);
    pop_cycles(4);
    @(negedge clk);
    check(expq.size() == 0, "R2 final scoreboard empty", expq.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule